// File: doc/BRIEF.md
# Back-EMF Minimum Speed Sampler with Distance Accumulator

This block turns the back-EMF of a brushed DC motor into a speed figure and a running distance. While the PWM stage has the bridge switched off, the motor's terminal voltage reflects its speed, and an ADC delivers samples of it. During each such off interval the block keeps the smallest valid sample it sees. When the interval closes, that minimum becomes the speed reading for the period. The block raises a one-cycle strobe and adds the reading to a wide distance accumulator, or subtracts it when the motor runs in reverse.

The minimum is used rather than an average. At high speed or heavy load only a handful of samples fit into the off interval, and commutation ripple pushes single readings upward, so the smallest one is the most dependable. An off interval that yields no valid sample leaves the speed reading and the accumulator as they were. A host can zero the accumulator at any time.

Top module: `bemf_odometer`

## Requirements
- R1: After reset, speedOut is 0, speedValid is 0 and odometer is 0.
- R2: While pwmOff is 1, every cycle with sampleValid 1 offers sampleData as a candidate, and cycles with sampleValid 0 offer none. The reading latched for a window is the smallest candidate of that window.
- R3: Samples presented while pwmOff is 0 have no effect on any reading.
- R4: The minimum restarts at every rising edge of pwmOff: a candidate in the first cycle of the window counts, and no value from an earlier window carries over.
- R5: On the first clock edge at which pwmOff is 0 after a window with at least one candidate, speedOut takes the window minimum, and speedValid is 1 for exactly the following cycle.
- R6: At that same edge the odometer adds the reading when dirReverse is 0 and subtracts it when dirReverse is 1, modulo 2^32, with dirReverse sampled at that edge.
- R7: A window without any candidate leaves speedOut and odometer unchanged and produces no speedValid pulse.
- R8: odoClear at a clock edge zeroes the odometer at that edge and takes priority over an accumulation at the same edge.
- R9: The full-scale sample 1023 (all ones) is a valid reading and is latched and accumulated as such.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwmOff | input | 1 | High while the bridge is in its off interval |
| sampleValid | input | 1 | ADC sample present this cycle |
| sampleData | input | 10 | Unsigned back-EMF sample |
| dirReverse | input | 1 | 1: subtract the reading from the odometer |
| odoClear | input | 1 | Zero the odometer |
| speedOut | output | 10 | Speed reading of the latest completed window |
| speedValid | output | 1 | One-cycle strobe for a new reading |
| odometer | output | 32 | Accumulated distance |

## Verification
Windows are driven with the minimum placed first, in the middle and in the last cycle. This separates a true minimum from a first-sample or last-sample latch. Invalid samples inside a window, and valid samples outside one, that are lower than the real minimum show whether the qualifiers are honoured. A high window after a low one catches a minimum that is not restarted. An empty window, a reverse window that wraps below zero, a clear that coincides with a window end and a full-scale sample cover the remaining corners.

// File: rtl/bemf_pkg.sv
package bemf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic openWin;     // first cycle of an off window
    logic takeSample;  // a qualifying sample is on the bus
    logic commit;      // window closed with at least one candidate
  } bemfCtl_t;
endpackage

// File: rtl/bemf_ctrl.sv
module bemf_ctrl
  import bemf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwmOff,
  input  logic     sampleValid,
  output bemfCtl_t ctl
);
  logic offQ;
  logic seenQ;

  always_comb begin
    ctl.openWin    = pwmOff & ~offQ;
    ctl.takeSample = pwmOff & sampleValid;
    ctl.commit     = ~pwmOff & offQ & seenQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offQ  <= 1'b0;
      seenQ <= 1'b0;
    end else begin
      offQ <= pwmOff;
      if (ctl.openWin) seenQ <= ctl.takeSample;
      else             seenQ <= seenQ | ctl.takeSample;
    end
  end
endmodule

// File: rtl/bemf_datapath.sv
module bemf_datapath
  import bemf_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int ODO_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bemfCtl_t            ctl,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                dirReverse,
  input  logic                odoClear,
  output logic [SAMPLE_W-1:0] speedOut,
  output logic                speedValid,
  output logic [ODO_W-1:0]    odometer
);
  localparam logic [SAMPLE_W-1:0] MIN_INIT = '1;

  logic [SAMPLE_W-1:0] minReg;
  logic [ODO_W-1:0]    extSpeed;
  logic [ODO_W-1:0]    odoNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      minReg <= MIN_INIT;
    end else if (ctl.openWin) begin
      minReg <= ctl.takeSample ? sampleData : MIN_INIT;
    end else if (ctl.takeSample && (sampleData < minReg)) begin
      minReg <= sampleData;
    end
  end

  always_comb begin
    extSpeed = ODO_W'(minReg);
    odoNext  = dirReverse ? (odometer - extSpeed) : (odometer + extSpeed);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      speedOut   <= '0;
      speedValid <= 1'b0;
      odometer   <= '0;
    end else begin
      speedValid <= ctl.commit;
      if (ctl.commit) speedOut <= minReg;
      if (odoClear)        odometer <= '0;
      else if (ctl.commit) odometer <= odoNext;
    end
  end
endmodule

// File: rtl/bemf_odometer.sv
module bemf_odometer
  import bemf_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int ODO_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwmOff,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                dirReverse,
  input  logic                odoClear,
  output logic [SAMPLE_W-1:0] speedOut,
  output logic                speedValid,
  output logic [ODO_W-1:0]    odometer
);
  bemfCtl_t ctl;

  bemf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwmOff(pwmOff),
    .sampleValid(sampleValid), .ctl(ctl)
  );

  bemf_datapath #(.SAMPLE_W(SAMPLE_W), .ODO_W(ODO_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .sampleData(sampleData),
    .dirReverse(dirReverse), .odoClear(odoClear),
    .speedOut(speedOut), .speedValid(speedValid), .odometer(odometer)
  );
endmodule

// File: rtl/bemf_odometer_chk.sv
module bemf_odometer_chk #(
  parameter int SAMPLE_W = 10,
  parameter int ODO_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwmOff,
  input logic                dirReverse,
  input logic                odoClear,
  input logic [SAMPLE_W-1:0] speedOut,
  input logic                speedValid,
  input logic [ODO_W-1:0]    odometer
);
  // R5: strobe lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    speedValid |=> !speedValid);

  // R5: strobe only follows a falling edge of pwmOff
  a_r5_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    speedValid |-> (!$past(pwmOff) && $past(pwmOff, 2)));

  // R7: the reading never moves without its strobe
  a_r7_speed_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(speedOut) |-> speedValid);

  // R8: clear empties the accumulator
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    odoClear |=> (odometer == '0));

  // R7: accumulator moves only on a reading or a clear
  a_r7_odo_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(odometer) |-> (speedValid || $past(odoClear)));

  // R6: signed step equals the new reading
  a_r6_odo_step: assert property (@(posedge clk) disable iff (!rst_n)
    (speedValid && !$past(odoClear)) |->
      (odometer == ($past(dirReverse) ? ($past(odometer) - ODO_W'(speedOut))
                                      : ($past(odometer) + ODO_W'(speedOut)))));
endmodule

bind bemf_odometer bemf_odometer_chk #(.SAMPLE_W(SAMPLE_W), .ODO_W(ODO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwmOff(pwmOff), .dirReverse(dirReverse),
  .odoClear(odoClear), .speedOut(speedOut), .speedValid(speedValid),
  .odometer(odometer)
);

// File: tb/tb_bemf_odometer.sv
`timescale 1ns/1ps
module tb_bemf_odometer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwmOff = 1'b0;
  logic        sampleValid = 1'b0;
  logic [9:0]  sampleData = '0;
  logic        dirReverse = 1'b0;
  logic        odoClear = 1'b0;
  logic [9:0]  speedOut;
  logic        speedValid;
  logic [31:0] odometer;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [9:0]  expSpeed = '0;
  logic [31:0] expOdo = '0;

  always #2.5 clk = ~clk;

  bemf_odometer dut (
    .clk(clk), .rst_n(rst_n), .pwmOff(pwmOff), .sampleValid(sampleValid),
    .sampleData(sampleData), .dirReverse(dirReverse), .odoClear(odoClear),
    .speedOut(speedOut), .speedValid(speedValid), .odometer(odometer)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic off, input logic vld, input logic [9:0] d,
                       input logic rev = 1'b0, input logic clr = 1'b0);
    @(negedge clk);
    pwmOff = off; sampleValid = vld; sampleData = d; dirReverse = rev; odoClear = clr;
  endtask

  // close window, then check result one edge later
  task automatic closeAndCheck(input string req, input logic rev, input logic clr,
                               input logic pulse);
    drive(1'b0, 1'b0, 10'd0, rev, clr);
    @(negedge clk);
    check({req, " speedValid"}, 32'(speedValid), 32'(pulse));
    check({req, " speedOut"}, 32'(speedOut), 32'(expSpeed));
    check({req, " odometer"}, odometer, expOdo);
    drive(1'b0, 1'b0, 10'd0);
    check({req, " strobe drop"}, 32'(speedValid), 32'd0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 speedOut", 32'(speedOut), 32'd0);
    check("R1 speedValid", 32'(speedValid), 32'd0);
    check("R1 odometer", odometer, 32'd0);
  endtask

  task automatic testBasicMin();
    drive(1, 1, 10'd500); drive(1, 1, 10'd300); drive(1, 1, 10'd700);
    expSpeed = 300; expOdo += 300;
    closeAndCheck("R2/R5/R6 min middle", 1'b0, 1'b0, 1'b1);
    drive(1, 1, 10'd90); drive(1, 1, 10'd200); drive(1, 1, 10'd150);
    expSpeed = 90; expOdo += 90;
    closeAndCheck("R4 min first cycle", 1'b0, 1'b0, 1'b1);
    drive(1, 1, 10'd800); drive(1, 0, 10'd0); drive(1, 1, 10'd610);
    expSpeed = 610; expOdo += 610;
    closeAndCheck("R2 min last", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testQualifiers();
    drive(1, 0, 10'd50); drive(1, 1, 10'd400); drive(1, 0, 10'd5);
    expSpeed = 400; expOdo += 400;
    closeAndCheck("R2 invalid ignored", 1'b0, 1'b0, 1'b1);
    drive(0, 1, 10'd10); drive(0, 1, 10'd3);
    check("R3 no strobe outside", 32'(speedValid), 32'd0);
    drive(1, 1, 10'd600);
    expSpeed = 600; expOdo += 600;
    closeAndCheck("R3 outside ignored", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testRestart();
    drive(1, 1, 10'd20);
    expSpeed = 20; expOdo += 20;
    closeAndCheck("R4 low window", 1'b0, 1'b0, 1'b1);
    drive(1, 1, 10'd900); drive(1, 1, 10'd950);
    expSpeed = 900; expOdo += 900;
    closeAndCheck("R4 restart", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testReverse();
    drive(1, 1, 10'd1000);
    expSpeed = 1000; expOdo -= 1000;
    closeAndCheck("R6 reverse", 1'b1, 1'b0, 1'b1);
    drive(0, 0, 10'd0, 1'b0, 1'b1);
    expOdo = 0;
    @(negedge clk);
    check("R8 clear alone", odometer, 32'd0);
    drive(1, 1, 10'd5);
    expSpeed = 5; expOdo = 32'hFFFF_FFFB;
    closeAndCheck("R6 wrap", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testEmpty();
    drive(1, 0, 10'd1); drive(1, 0, 10'd2);
    closeAndCheck("R7 empty window", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testClearCommit();
    drive(1, 1, 10'd77);
    expSpeed = 77; expOdo = 0;
    closeAndCheck("R8 clear beats add", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic testFullScale();
    drive(1, 1, 10'd1023); drive(1, 1, 10'd1023);
    expSpeed = 1023; expOdo += 1023;
    closeAndCheck("R9 full scale", 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testBasicMin();
    testQualifiers();
    testRestart();
    testReverse();
    testEmpty();
    testClearCommit();
    testFullScale();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule